// File: doc/BRIEF.md
# Burst Beat Address Generator

This block walks through the beat addresses of one memory burst. A load strobe captures the start address, the bytes per beat (as a log2 code), the beat count and the burst kind (incrementing or wrapping). From the cycle after the load, the block presents the first beat address. Each advance strobe moves it to the next beat until the final beat, which is marked by a last flag.

Wrapping bursts stay inside a window of beat size times beat count bytes. The window's lower edge is the start address with its low log2(window) bits cleared. When a wrapping burst passes the top of the window, it folds back to that lower edge. Requests that cannot be carried out raise an error flag at load and produce no beats. These are a wrap with an unsupported length, a wrap with a misaligned start, or a beat size wider than the data bus. The error flag stays set until the next load.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, busy_o, last_o and err_o are 0 and addr_o is 0.
- R2: One cycle after an accepted load, busy_o is 1 and addr_o equals start_addr_i unchanged, for both wrap_i=0 (incrementing) and wrap_i=1 (wrapping).
- R3: In an incrementing burst, each next_i while busy moves addr_o to the previous address plus 2^size_i bytes, modulo 2^ADDR_W. size_i is log2 of the bytes per beat.
- R4: In a wrapping burst, the window holds 2^size_i*(len_i+1) bytes and its lower edge is start_addr_i with the low log2(window) bits cleared. An advance that would reach the window's upper edge returns addr_o to the lower edge instead.
- R5: len_i encodes beats minus one. last_o is 1 exactly while the beat index equals len_i. A next_i on that beat ends the burst, so busy_o and last_o drop the following cycle.
- R6: A wrapping load whose len_i is not 1, 3, 7 or 15 (2, 4, 8 or 16 beats) sets err_o and produces no beats: busy_o stays 0 even when next_i is asserted.
- R7: A wrapping load whose start_addr_i is not a multiple of 2^size_i sets err_o with no beats. An incrementing load has no alignment restriction.
- R8: A load of either kind with size_i greater than MAX_SIZE sets err_o with no beats.
- R9: err_o holds its value until the next load. A legal load clears it.
- R10: next_i while not busy has no effect, and addr_o holds while neither next_i nor load_i is asserted.
- R11: load_i asserted during a burst abandons that burst and starts the new one. load_i takes priority over next_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture burst parameters |
| start_addr_i | input | ADDR_W | First beat address |
| size_i | input | SIZE_W | log2 of bytes per beat |
| len_i | input | LEN_W | Beats minus one |
| wrap_i | input | 1 | 1 = wrapping, 0 = incrementing |
| next_i | input | 1 | Advance to the next beat |
| busy_o | output | 1 | Burst in progress, addr_o valid |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Last load was illegal |

## Verification
The bench sweeps every size code, every length and both burst kinds, over start offsets that are aligned, misaligned and placed in the middle of a wrap window. A wrong fold mask would land beats outside the window or fold too early. A counter off by one would move last_o a beat early or late. The sweep also covers illegal sizes, non-power-of-two wrap lengths and incrementing bursts that cross the top of the address space. A legality check that is too loose would start beats on bad requests, and one that is too strict would reject misaligned incrementing bursts. Separate cases cover an advance while idle, a mid-burst reload and an error cleared by a legal load. A design that leaks a stale advance or lets an old burst continue would show up there.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    BURST_INCR = 1'b0,
    BURST_WRAP = 1'b1
  } burst_kind_e;
  localparam int unsigned WRAP_BEATS_MAX = 16;
endpackage

// File: rtl/burst_req_check.sv
module burst_req_check #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned MAX_SIZE = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wrap_i,
  output logic              legal_o
);
  logic [ADDR_W-1:0] align_mask;
  logic [LEN_W:0]    len_p1;
  logic              size_ok, align_ok, len_ok;

  always_comb begin
    for (int i = 0; i < int'(ADDR_W); i++) align_mask[i] = (i < int'(size_i));
  end

  assign len_p1   = {1'b0, len_i} + (LEN_W+1)'(1);
  assign size_ok  = int'(size_i) <= int'(MAX_SIZE);
  assign align_ok = (addr_i & align_mask) == '0;
  // power of two beats, at least 2, at most the wrap maximum
  assign len_ok   = (len_i != '0) && ((len_i & len_p1[LEN_W-1:0]) == '0)
                    && (int'(len_i) < int'(burst_pkg::WRAP_BEATS_MAX));
  assign legal_o  = size_ok && (!wrap_i || (align_ok && len_ok));
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [ADDR_W-1:0] win_mask_o
);
  logic [ADDR_W-1:0] bytes, sum;
  int                win_log2;

  assign bytes    = ADDR_W'(1) << size_i;
  assign sum      = addr_i + bytes;
  // legal wrap lengths are 2^k-1, so popcount gives k
  assign win_log2 = int'(size_i) + $countones(len_i);

  always_comb begin
    for (int i = 0; i < int'(ADDR_W); i++) win_mask_o[i] = (i < win_log2);
  end

  assign next_addr_o = wrap_i ? ((addr_i & ~win_mask_o) | (sum & win_mask_o)) : sum;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             at_end_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + LEN_W'(1);
  end

  assign at_end_o = cnt_q == len_i;

  a_r5_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clear_i |=> cnt_q != '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned MAX_SIZE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wrap_i,
  input  logic              next_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              err_o
);
  import burst_pkg::*;

  burst_kind_e       kind_q;
  logic [ADDR_W-1:0] addr_q, next_addr, win_mask;
  logic [SIZE_W-1:0] size_q;
  logic [LEN_W-1:0]  len_q;
  logic              busy_q, err_q, legal, at_end, adv;

  burst_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE))
    i_check (.addr_i(start_addr_i), .size_i(size_i), .len_i(len_i), .wrap_i(wrap_i),
             .legal_o(legal));

  burst_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W))
    i_step (.addr_i(addr_q), .size_i(size_q), .len_i(len_q), .wrap_i(kind_q == BURST_WRAP),
            .next_addr_o(next_addr), .win_mask_o(win_mask));

  assign adv = busy_q && next_i && !load_i;

  burst_beat_ctr #(.LEN_W(LEN_W))
    i_ctr (.clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load_i), .inc_i(adv && !at_end),
           .len_i(len_q), .at_end_o(at_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= BURST_INCR;
      addr_q <= '0;
      size_q <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (load_i) begin
      kind_q <= wrap_i ? BURST_WRAP : BURST_INCR;
      addr_q <= start_addr_i;
      size_q <= size_i;
      len_q  <= len_i;
      busy_q <= legal;
      err_q  <= !legal;
    end else if (adv) begin
      if (at_end) busy_q <= 1'b0;
      else        addr_q <= next_addr;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign last_o = busy_q && at_end;
  assign err_o  = err_q;

  a_r5_last_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> busy_o);
  a_r6_err_no_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && busy_o));
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !load_i |=> $stable(addr_o) && !busy_o);
  a_r5_end_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && last_o && next_i && !load_i |=> !busy_o);
  a_r3_incr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o && next_i && !load_i && kind_q == BURST_INCR
    |=> addr_o == $past(addr_o) + (ADDR_W'(1) << size_q));
  a_r4_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && next_i && !load_i && kind_q == BURST_WRAP
    |=> (addr_o & ~win_mask) == ($past(addr_o) & ~win_mask));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 16, LW = 4, SW = 3, MS = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          load = 1'b0, wrap = 1'b0, nxt = 1'b0;
  logic [AW-1:0] start = '0;
  logic [SW-1:0] size = '0;
  logic [LW-1:0] len = '0;
  logic          busy, last, err;
  logic [AW-1:0] addr;
  int            n_checks = 0, n_errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW), .MAX_SIZE(MS)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_addr_i(start), .size_i(size),
    .len_i(len), .wrap_i(wrap), .next_i(nxt), .busy_o(busy), .addr_o(addr),
    .last_o(last), .err_o(err));

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_legal(bit w, int s, int l, int a);
    if (s > MS) return 0;
    if (!w) return 1;
    if (!(l == 1 || l == 3 || l == 7 || l == 15)) return 0;
    return (a % (1 << s)) == 0;
  endfunction

  function automatic int exp_addr(bit w, int s, int l, int a, int b);
    int win, base;
    if (!w) return (a + b * (1 << s)) % (1 << AW);
    win  = (l + 1) * (1 << s);
    base = a - (a % win);
    return base + ((a - base + b * (1 << s)) % win);
  endfunction

  task automatic do_load(bit w, int s, int l, int a);
    @(negedge clk);
    load = 1'b1; wrap = w; size = SW'(s); len = LW'(l); start = AW'(a); nxt = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_burst(bit w, int s, int l, int a, bit stall);
    bit ok;
    ok = is_legal(w, s, l, a);
    do_load(w, s, l, a);
    if (!ok) begin
      string rq;
      rq = (s > MS) ? "R8" : ((l == 1 || l == 3 || l == 7 || l == 15) ? "R7" : "R6");
      check(rq, "err", int'(err), 1);
      check(rq, "busy", int'(busy), 0);
      nxt = 1'b1;
      @(negedge clk);
      nxt = 1'b0;
      check("R6", "busy after next", int'(busy), 0);
      check("R9", "err held", int'(err), 1);
      return;
    end
    check("R9", "err clear", int'(err), 0);
    for (int b = 0; b <= l; b++) begin
      check(b == 0 ? "R2" : (w ? "R4" : "R3"), "addr", int'(addr), exp_addr(w, s, l, a, b));
      check("R5", "last", int'(last), int'(b == l));
      check("R5", "busy", int'(busy), 1);
      if (stall && b == 1) begin
        @(negedge clk);
        check("R10", "hold addr", int'(addr), exp_addr(w, s, l, a, b));
      end
      nxt = 1'b1;
      @(negedge clk);
      nxt = 1'b0;
    end
    check("R5", "busy end", int'(busy), 0);
    check("R5", "last end", int'(last), 0);
  endtask

  initial begin
    #1;
    check("R1", "busy", int'(busy), 0);
    check("R1", "last", int'(last), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "addr", int'(addr), 0);
    #30 rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s <= MS + 1; s++)
        for (int l = 0; l < 16; l++) begin
          run_burst(w[0], s, l, 16'h1200, 1'b0);
          run_burst(w[0], s, l, 16'h1200 + 3 * (1 << s), l == 3);
          run_burst(w[0], s, l, 16'h1201, 1'b0);
          run_burst(w[0], s, l, 16'hFFF8 & ~((1 << s) - 1), 1'b0);
        end
    // R10: next while idle
    run_burst(1'b0, 1, 2, 16'h0040, 1'b0);
    nxt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    nxt = 1'b0;
    check("R10", "idle addr", int'(addr), 16'h0044);
    check("R10", "idle busy", int'(busy), 0);
    // R11: reload mid-burst, with a simultaneous next
    do_load(1'b0, 2, 7, 16'h0100);
    nxt = 1'b1;
    @(negedge clk);
    check("R11", "mid addr", int'(addr), 16'h0104);
    load = 1'b1; wrap = 1'b1; size = 3'd0; len = 4'd3; start = 16'h0203;
    @(negedge clk);
    load = 1'b0; nxt = 1'b0;
    check("R11", "restart addr", int'(addr), 16'h0203);
    check("R11", "restart last", int'(last), 0);
    check("R11", "restart busy", int'(busy), 1);
    nxt = 1'b1;
    @(negedge clk);
    nxt = 1'b0;
    check("R11", "fold addr", int'(addr), 16'h0200);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule